// File: doc/BRIEF.md
# Handle-Passing Message Mailbox

This block carries variable-length messages between a management processor and an embedded switch controller. It does not copy message words through a queue. Each message sits in one of a pool of fixed-size buffers in a shared on-chip memory, and only the buffer's handle moves between the two sides. A hardware free list hands out and takes back buffer handles. Two handle queues carry posted handles, one for each direction.

To send a message, the processor reads the acquire register to get a free handle. It writes the message body into that buffer through the buffer window, then writes the handle to the post register. Each post pulses an event towards the controller, which pops the handle from its queue and reads the buffer through its own memory port. In the other direction, the controller acquires a buffer, fills it and posts the handle. The processor sees a mail-arrive interrupt, reads the handle from the fetch register, and then reads the body. Either side gives the buffer back by writing its handle to the release path.

A handle is a buffer index with one extra top bit. The all-ones value is reserved as "no handle".

Top module: `msg_mailbox`

## Requirements
- R1: After reset all 16 buffers are free, both handle queues are empty, `mail_irq_o` and `ctrl_evt_o` are low, and both STATUS flags read 0.
- R2: A read of ACQ (offset 0x00) returns the lowest-numbered free handle and removes it from the free list. When the processor reads ACQ in the same cycle as `ctrl_acq_i` is high, the processor is served and `ctrl_acq_gnt_o` stays low. When only `ctrl_acq_i` is high and a buffer is free, `ctrl_acq_gnt_o` is high with the lowest free handle on `ctrl_acq_hnd_o`.
- R3: When no buffer is free, a read of ACQ returns 0x1F in bits 4:0 and sets sticky STATUS bit 0. In that state `ctrl_acq_gnt_o` stays low.
- R4: Addresses with bit 7 set form the buffer window, where bits 6:3 select the buffer and bits 2:0 select the word. Processor writes there are read back one cycle after the read request. The controller port sees the same memory, read combinationally at `ctrl_mem_addr_i` = {buffer, word}.
- R5: A write to POST (offset 0x01) with a valid handle appends the handle to the controller queue. `ctrl_evt_o` is high for exactly the one cycle after the write. `ctrl_hnd_o` shows the oldest handle while `ctrl_hnd_vld_o` is high, and `ctrl_pop_i` removes it.
- R6: A POST write is dropped, with no event, when bit 4 of the handle is set or when the controller queue already holds 16 handles.
- R7: `ctrl_post_i` with a valid handle appends it to the processor queue. `mail_irq_o` is high for as long as that queue is not empty.
- R8: A read of FETCH (offset 0x02) returns and removes the oldest processor-bound handle, and `mail_irq_o` falls after the last one is taken. A FETCH of an empty queue returns 0x1F.
- R9: A write to RELEASE (offset 0x03), or `ctrl_rel_i`, returns a handle to the free list. Releasing a handle that is already free, or that has bit 4 set, changes nothing and sets sticky STATUS bit 1.
- R10: Writing STATUS (offset 0x04) clears each flag whose bit is written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Processor access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register offset or buffer window address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| bus_rvalid_o | output | 1 | Read data valid |
| mail_irq_o | output | 1 | Mail-arrive interrupt to the processor |
| ctrl_acq_i | input | 1 | Controller requests a free buffer |
| ctrl_acq_gnt_o | output | 1 | Controller request served this cycle |
| ctrl_acq_hnd_o | output | 5 | Handle granted to the controller |
| ctrl_mem_we_i | input | 1 | Controller buffer write |
| ctrl_mem_addr_i | input | 7 | Controller buffer address {buffer, word} |
| ctrl_mem_wdata_i | input | 32 | Controller buffer write data |
| ctrl_mem_rdata_o | output | 32 | Controller buffer read data |
| ctrl_post_i | input | 1 | Controller posts a handle to the processor |
| ctrl_post_hnd_i | input | 5 | Handle posted by the controller |
| ctrl_evt_o | output | 1 | One-cycle event per handle posted to the controller |
| ctrl_hnd_vld_o | output | 1 | Controller queue not empty |
| ctrl_hnd_o | output | 5 | Oldest handle in the controller queue |
| ctrl_pop_i | input | 1 | Controller removes the oldest handle |
| ctrl_rel_i | input | 1 | Controller releases a handle |
| ctrl_rel_hnd_i | input | 5 | Handle released by the controller |

## Verification
The buffer window is checked with distinct data in the first and last word of a buffer. This tells a correct word decode from a collapsed one. Both queue directions are driven with two handles in sequence, which shows whether queue order and interrupt timing follow the last pop rather than the first. The free list is walked from a partial pool down to exhaustion, with single and double releases from both sides in between. This separates lowest-free selection, the reserved no-handle value and the error flags. A same-cycle acquire from both sides and a seventeenth post to a full queue check the priority and the drop rule.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    REG_ACQ   = 3'd0,
    REG_POST  = 3'd1,
    REG_FETCH = 3'd2,
    REG_REL   = 3'd3,
    REG_STAT  = 3'd4
  } reg_e;

  localparam int unsigned STAT_UNF = 0;
  localparam int unsigned STAT_DBL = 1;
endpackage

// File: rtl/mbox_free_list.sv
module mbox_free_list #(
  parameter int unsigned NBUF = 16,
  localparam int unsigned IW  = $clog2(NBUF),
  localparam int unsigned HW  = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acq_a_i,
  input  logic          acq_b_i,
  input  logic          rel_a_i,
  input  logic [HW-1:0] rel_a_hnd_i,
  input  logic          rel_b_i,
  input  logic [HW-1:0] rel_b_hnd_i,
  output logic [HW-1:0] hnd_o,
  output logic          empty_o,
  output logic          gnt_b_o,
  output logic          rel_err_o
);
  logic [NBUF-1:0] free_q, free_d;
  logic [IW-1:0]   lo_idx;
  logic            any_free;
  logic            rel_a_ok, rel_b_ok;

  always_comb begin
    lo_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (free_q[i]) lo_idx = IW'(i);
  end

  assign any_free  = |free_q;
  assign empty_o   = !any_free;
  assign hnd_o     = any_free ? {1'b0, lo_idx} : '1;
  assign gnt_b_o   = acq_b_i && !acq_a_i && any_free;

  assign rel_a_ok  = rel_a_i && !rel_a_hnd_i[HW-1] && !free_q[rel_a_hnd_i[IW-1:0]];
  assign rel_b_ok  = rel_b_i && !rel_b_hnd_i[HW-1] && !free_q[rel_b_hnd_i[IW-1:0]];
  assign rel_err_o = (rel_a_i && !rel_a_ok) || (rel_b_i && !rel_b_ok);

  always_comb begin
    free_d = free_q;
    if ((acq_a_i || acq_b_i) && any_free) free_d[lo_idx] = 1'b0;
    if (rel_a_ok) free_d[rel_a_hnd_i[IW-1:0]] = 1'b1;
    if (rel_b_ok) free_d[rel_b_hnd_i[IW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) free_q <= '1;
    else         free_q <= free_d;

  // R2
  acq_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_a_i && any_free) |=> !free_q[$past(lo_idx)]);
  // R2
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_a_i |-> !gnt_b_o);
  // R9
  rel_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_a_ok |=> free_q[$past(rel_a_hnd_i[IW-1:0])]);
endmodule

// File: rtl/mbox_hfifo.sv
module mbox_hfifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 5,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) if (do_push) mem_q[wr_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);
  // R8
  order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && push_i) |=> (data_o == $past(data_i)));
endmodule

// File: rtl/mbox_buf_mem.sv
module mbox_buf_mem #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 32,
  localparam int unsigned MAW  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           a_we_i,
  input  logic [MAW-1:0] a_addr_i,
  input  logic [DW-1:0]  a_wdata_i,
  output logic [DW-1:0]  a_rdata_o,
  input  logic           b_we_i,
  input  logic [MAW-1:0] b_addr_i,
  input  logic [DW-1:0]  b_wdata_i,
  output logic [DW-1:0]  b_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign a_rdata_o = mem_q[a_addr_i];
  assign b_rdata_o = mem_q[b_addr_i];

  // processor port wins on a same-word collision
  always_ff @(posedge clk_i) begin
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
  end

  // R4
  a_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we_i |=> (mem_q[$past(a_addr_i)] == $past(a_wdata_i)));
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned NBUF  = 16,
  parameter int unsigned WORDS = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(NBUF),
  localparam int unsigned HW   = IW + 1,
  localparam int unsigned WW   = $clog2(WORDS),
  localparam int unsigned MAW  = IW + WW,
  localparam int unsigned AW   = MAW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_req_i,
  input  logic           bus_we_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  output logic           bus_rvalid_o,
  output logic           mail_irq_o,
  input  logic           ctrl_acq_i,
  output logic           ctrl_acq_gnt_o,
  output logic [HW-1:0]  ctrl_acq_hnd_o,
  input  logic           ctrl_mem_we_i,
  input  logic [MAW-1:0] ctrl_mem_addr_i,
  input  logic [DW-1:0]  ctrl_mem_wdata_i,
  output logic [DW-1:0]  ctrl_mem_rdata_o,
  input  logic           ctrl_post_i,
  input  logic [HW-1:0]  ctrl_post_hnd_i,
  output logic           ctrl_evt_o,
  output logic           ctrl_hnd_vld_o,
  output logic [HW-1:0]  ctrl_hnd_o,
  input  logic           ctrl_pop_i,
  input  logic           ctrl_rel_i,
  input  logic [HW-1:0]  ctrl_rel_hnd_i
);
  logic          win, reg_hit, rd, wr;
  logic          acq_rd, fetch_rd, stat_rd, post_wr, rel_wr, stat_wr, mem_we;
  logic [HW-1:0] free_hnd, p_head, wr_hnd;
  logic          fl_empty, rel_err;
  logic          c_empty, c_full, p_empty, p_full;
  logic          post_ok, cpost_ok;
  logic [DW-1:0] mem_rdata;
  logic          unf_q, dbl_q, evt_q;

  assign win      = bus_addr_i[AW-1];
  assign reg_hit  = !win && (bus_addr_i[AW-2:3] == '0);
  assign rd       = bus_req_i && !bus_we_i;
  assign wr       = bus_req_i && bus_we_i;
  assign acq_rd   = rd && reg_hit && (bus_addr_i[2:0] == REG_ACQ);
  assign fetch_rd = rd && reg_hit && (bus_addr_i[2:0] == REG_FETCH);
  assign stat_rd  = rd && reg_hit && (bus_addr_i[2:0] == REG_STAT);
  assign post_wr  = wr && reg_hit && (bus_addr_i[2:0] == REG_POST);
  assign rel_wr   = wr && reg_hit && (bus_addr_i[2:0] == REG_REL);
  assign stat_wr  = wr && reg_hit && (bus_addr_i[2:0] == REG_STAT);
  assign mem_we   = wr && win;
  assign wr_hnd   = bus_wdata_i[HW-1:0];

  assign post_ok  = post_wr && !wr_hnd[HW-1] && !c_full;
  assign cpost_ok = ctrl_post_i && !ctrl_post_hnd_i[HW-1] && !p_full;

  mbox_free_list #(.NBUF(NBUF)) u_free (
    .clk_i, .rst_ni,
    .acq_a_i     (acq_rd),
    .acq_b_i     (ctrl_acq_i),
    .rel_a_i     (rel_wr),
    .rel_a_hnd_i (wr_hnd),
    .rel_b_i     (ctrl_rel_i),
    .rel_b_hnd_i (ctrl_rel_hnd_i),
    .hnd_o       (free_hnd),
    .empty_o     (fl_empty),
    .gnt_b_o     (ctrl_acq_gnt_o),
    .rel_err_o   (rel_err)
  );
  assign ctrl_acq_hnd_o = free_hnd;

  mbox_hfifo #(.DEPTH(NBUF), .W(HW)) u_to_ctrl (
    .clk_i, .rst_ni,
    .push_i  (post_ok),
    .data_i  (wr_hnd),
    .pop_i   (ctrl_pop_i),
    .data_o  (ctrl_hnd_o),
    .empty_o (c_empty),
    .full_o  (c_full)
  );

  mbox_hfifo #(.DEPTH(NBUF), .W(HW)) u_to_proc (
    .clk_i, .rst_ni,
    .push_i  (cpost_ok),
    .data_i  (ctrl_post_hnd_i),
    .pop_i   (fetch_rd),
    .data_o  (p_head),
    .empty_o (p_empty),
    .full_o  (p_full)
  );

  mbox_buf_mem #(.DEPTH(NBUF * WORDS), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .a_we_i    (mem_we),
    .a_addr_i  (bus_addr_i[MAW-1:0]),
    .a_wdata_i (bus_wdata_i),
    .a_rdata_o (mem_rdata),
    .b_we_i    (ctrl_mem_we_i),
    .b_addr_i  (ctrl_mem_addr_i),
    .b_wdata_i (ctrl_mem_wdata_i),
    .b_rdata_o (ctrl_mem_rdata_o)
  );

  assign mail_irq_o     = !p_empty;
  assign ctrl_hnd_vld_o = !c_empty;
  assign ctrl_evt_o     = evt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      unf_q        <= 1'b0;
      dbl_q        <= 1'b0;
      evt_q        <= 1'b0;
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      evt_q        <= post_ok;
      bus_rvalid_o <= rd;
      if (acq_rd && fl_empty)                  unf_q <= 1'b1;
      else if (stat_wr && bus_wdata_i[STAT_UNF]) unf_q <= 1'b0;
      if (rel_err)                             dbl_q <= 1'b1;
      else if (stat_wr && bus_wdata_i[STAT_DBL]) dbl_q <= 1'b0;
      if (rd) begin
        if (win)           bus_rdata_o <= mem_rdata;
        else if (acq_rd)   bus_rdata_o <= {{(DW-HW){1'b0}}, free_hnd};
        else if (fetch_rd) bus_rdata_o <= {{(DW-HW){1'b0}}, p_empty ? {HW{1'b1}} : p_head};
        else if (stat_rd)  bus_rdata_o <= {{(DW-2){1'b0}}, dbl_q, unf_q};
        else               bus_rdata_o <= '0;
      end
    end

  // R5
  evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_ok |=> (ctrl_evt_o && ctrl_hnd_vld_o));
  // R6
  bad_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_wr && wr_hnd[HW-1]) |=> !ctrl_evt_o);
  // R7
  irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpost_ok |=> mail_irq_o);
  // R3
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_rd && fl_empty) |=> (bus_rdata_o[HW-1:0] == {HW{1'b1}} && unf_q));
  // R8
  fetch_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_rd && !mail_irq_o) |=> (bus_rdata_o[HW-1:0] == {HW{1'b1}}));
endmodule

// File: tb/msg_mailbox_test.sv
module msg_mailbox_test;
  localparam int unsigned HW  = 5;
  localparam int unsigned MAW = 7;
  localparam logic [7:0] A_ACQ = 8'h00, A_POST = 8'h01, A_FETCH = 8'h02,
                         A_REL = 8'h03, A_STAT = 8'h04;

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 8'h00, 32'h0000_0000, 4'd2},
    '{1'b0, 8'h80, 32'hA5A5_0000, 4'd4},
    '{1'b0, 8'h87, 32'h1234_5678, 4'd4},
    '{1'b1, 8'h87, 32'h1234_5678, 4'd4},
    '{1'b1, 8'h80, 32'hA5A5_0000, 4'd4},
    '{1'b1, 8'h00, 32'h0000_0001, 4'd2},
    '{1'b1, 8'h04, 32'h0000_0000, 4'd1},
    '{1'b1, 8'h02, 32'h0000_001F, 4'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, mail_irq;
  logic ctrl_acq = 0, ctrl_acq_gnt;
  logic [HW-1:0] ctrl_acq_hnd;
  logic ctrl_mem_we = 0;
  logic [MAW-1:0] ctrl_mem_addr = '0;
  logic [31:0] ctrl_mem_wdata = '0, ctrl_mem_rdata;
  logic ctrl_post = 0;
  logic [HW-1:0] ctrl_post_hnd = '0;
  logic ctrl_evt, ctrl_hnd_vld;
  logic [HW-1:0] ctrl_hnd;
  logic ctrl_pop = 0, ctrl_rel = 0;
  logic [HW-1:0] ctrl_rel_hnd = '0;

  int n_chk = 0, n_err = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  msg_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .mail_irq_o(mail_irq),
    .ctrl_acq_i(ctrl_acq), .ctrl_acq_gnt_o(ctrl_acq_gnt), .ctrl_acq_hnd_o(ctrl_acq_hnd),
    .ctrl_mem_we_i(ctrl_mem_we), .ctrl_mem_addr_i(ctrl_mem_addr),
    .ctrl_mem_wdata_i(ctrl_mem_wdata), .ctrl_mem_rdata_o(ctrl_mem_rdata),
    .ctrl_post_i(ctrl_post), .ctrl_post_hnd_i(ctrl_post_hnd),
    .ctrl_evt_o(ctrl_evt), .ctrl_hnd_vld_o(ctrl_hnd_vld), .ctrl_hnd_o(ctrl_hnd),
    .ctrl_pop_i(ctrl_pop), .ctrl_rel_i(ctrl_rel), .ctrl_rel_hnd_i(ctrl_rel_hnd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic c_post(input logic [HW-1:0] h);
    ctrl_post = 1; ctrl_post_hnd = h;
    @(negedge clk);
    ctrl_post = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(mail_irq), 0);
    chk("R1 evt", 32'(ctrl_evt), 0);
    chk("R1 ctrl queue", 32'(ctrl_hnd_vld), 0);
    bus_rd(A_STAT, rv); chk("R1 status", rv, 0);

    for (int i = 0; i < 8; i++) begin
      if (VECS[i].rd) begin
        bus_rd(VECS[i].addr, rv);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].data);
      end else bus_wr(VECS[i].addr, VECS[i].data);
    end

    // R5 post handle 0 to controller
    bus_wr(A_POST, 32'd0);
    chk("R5 evt high", 32'(ctrl_evt), 1);
    chk("R5 vld", 32'(ctrl_hnd_vld), 1);
    chk("R5 head", 32'(ctrl_hnd), 0);
    ctrl_mem_addr = 7'h07; #1;
    chk("R4 ctrl port read", ctrl_mem_rdata, 32'h1234_5678);
    @(negedge clk);
    chk("R5 evt one cycle", 32'(ctrl_evt), 0);
    ctrl_pop = 1; @(negedge clk); ctrl_pop = 0;
    chk("R5 pop", 32'(ctrl_hnd_vld), 0);

    // R2 controller acquire, R7 controller to processor
    ctrl_acq = 1; #1;
    chk("R2 ctrl gnt", 32'(ctrl_acq_gnt), 1);
    chk("R2 ctrl hnd", 32'(ctrl_acq_hnd), 2);
    @(negedge clk); ctrl_acq = 0;
    ctrl_mem_we = 1; ctrl_mem_addr = 7'h13; ctrl_mem_wdata = 32'hDEAD_BEEF;
    @(negedge clk); ctrl_mem_we = 0;
    c_post(5'd2);
    chk("R7 irq set", 32'(mail_irq), 1);
    c_post(5'd0);
    bus_rd(A_FETCH, rv); chk("R8 fetch first", rv, 2);
    chk("R7 irq held", 32'(mail_irq), 1);
    bus_rd(A_FETCH, rv); chk("R8 fetch second", rv, 0);
    chk("R8 irq cleared", 32'(mail_irq), 0);
    bus_rd(8'h93, rv); chk("R4 proc reads ctrl data", rv, 32'hDEAD_BEEF);

    // R9 release and double release
    bus_wr(A_REL, 32'd2);
    bus_rd(A_STAT, rv); chk("R9 good release no flag", rv, 0);
    bus_wr(A_REL, 32'd2);
    bus_rd(A_STAT, rv); chk("R9 double release flag", rv, 2);
    bus_wr(A_STAT, 32'd3);
    bus_rd(A_STAT, rv); chk("R10 clear", rv, 0);
    bus_rd(A_ACQ, rv); chk("R9 released reused", rv, 2);

    // R2 same-cycle priority
    ctrl_acq = 1; bus_req = 1; bus_we = 0; bus_addr = A_ACQ; #1;
    chk("R2 ctrl blocked", 32'(ctrl_acq_gnt), 0);
    @(negedge clk);
    rv = bus_rdata; bus_req = 0; ctrl_acq = 0;
    chk("R2 proc served", rv, 3);

    // R3 exhaust the pool
    for (int i = 4; i < 16; i++) begin
      bus_rd(A_ACQ, rv); chk("R2 sequential", rv, 32'(i));
    end
    bus_rd(A_ACQ, rv); chk("R3 none", rv, 32'h1F);
    bus_rd(A_STAT, rv); chk("R3 underflow flag", rv, 1);
    ctrl_acq = 1; #1;
    chk("R3 ctrl no gnt", 32'(ctrl_acq_gnt), 0);
    @(negedge clk); ctrl_acq = 0;
    bus_wr(A_STAT, 32'd1);
    bus_rd(A_STAT, rv); chk("R10 clear underflow", rv, 0);

    // R9 controller release path, invalid release
    ctrl_rel = 1; ctrl_rel_hnd = 5'd0; @(negedge clk); ctrl_rel = 0;
    bus_rd(A_ACQ, rv); chk("R9 ctrl release", rv, 0);
    bus_wr(A_REL, 32'h1F);
    bus_rd(A_STAT, rv); chk("R9 invalid release flag", rv, 2);

    // R6 invalid post and full queue
    bus_wr(A_POST, 32'h1F);
    chk("R6 invalid no evt", 32'(ctrl_evt), 0);
    chk("R6 invalid not queued", 32'(ctrl_hnd_vld), 0);
    for (int i = 0; i < 16; i++) bus_wr(A_POST, 32'd5);
    bus_wr(A_POST, 32'd6);
    chk("R6 full no evt", 32'(ctrl_evt), 0);
    begin
      int popped = 0;
      for (int i = 0; i < 20; i++) begin
        if (ctrl_hnd_vld) begin
          if (ctrl_hnd != 5'd5) chk("R6 dropped handle absent", 32'(ctrl_hnd), 5);
          popped++;
          ctrl_pop = 1; @(negedge clk); ctrl_pop = 0;
        end
      end
      chk("R6 queue depth", 32'(popped), 16);
    end
    bus_rd(A_FETCH, rv); chk("R8 empty fetch", rv, 32'h1F);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule